// File: doc/BRIEF.md
# Ping-Pong Frame Capture Buffer

This block gathers fixed-size acquisition frames into a storage area split into two halves. Accepted 32-bit samples fill one half while a host drains the other half. The host reads a whole frame by reading one fixed register address over and over, getting one 16-bit word per read. Each frame starts with a short header that the host can check. After that come the samples.

When a half holds a complete frame, the `frame_rdy` line goes high and stays high until the host writes the acknowledge register. The acknowledge frees that half. If the writer completes the other half before the acknowledge arrives, the block latches a sticky overrun flag. It then stops capturing and drops `frame_rdy` until the host issues a clear.

The number of channels and the number of scans per frame are programmable. The frame length is derived from them and checked against the half size. An optional ramp mode replaces the incoming samples with a predictable, never-zero pattern for link testing.

Top module: `pingpong_frame_buf`

Register map (`host_addr`):
- 0 is the data port.
- 1 is control: bit0 enable, bit1 ramp.
- 2 is the channel count (8 bits).
- 3 is the scan count (16 bits).
- 4 is status: bit0 ready, bit1 overrun, bit2 configuration error.
- 5 is acknowledge (write any value).
- 6 is clear (write any value).

Reset values:
- channels = 1
- scans = 1
- control = 0

## Requirements
- R1: A frame is read as 6 header words followed by, for each sample in arrival order, its upper 16 bits and then its lower 16 bits. The total is 6 + 2*channels*scans words. The header words are, in order:
  - 0xC3A5
  - the frame sequence number (0 for the first frame after reset or clear)
  - the channel count
  - the scan count
  - the total word count
  - the XOR of the five preceding header words
- R2: `frame_rdy` is high at the first clock edge after the last sample of a frame is accepted. It stays high until a write to the acknowledge register, after which it is low from the next edge.
- R3: While a completed frame waits in one half, accepted samples fill the other half. After the acknowledge, the frame in that other half becomes ready once it completes.
- R4: A read of address 0 while `frame_rdy` is high returns the next frame word on `host_rdata` one cycle later. A read past the last word returns 0.
- R5: A read of address 0 while `frame_rdy` is low returns 0 and does not advance the read position. The next read after the frame becomes ready returns the header mark 0xC3A5.
- R6: If a frame completes while the other half still holds an unacknowledged frame:
  - status bit1 (overrun) is set and stays set;
  - `frame_rdy` stays low;
  - further samples are ignored.
- R7: A write to the clear register clears the overrun flag, empties both halves and resets the frame sequence number to 0.
- R8: Status bit2 is set when channels or scans is 0, or when 6 + 2*channels*scans exceeds HALF_WORDS. A write setting enable is refused while status bit2 is set.
- R9: Writes to the channel and scan registers are ignored while enable is set.
- R10: With control bit1 set, the sample data is replaced by a 15-bit counter r. The counter starts at 1 after reset or clear, advances per accepted sample, and wraps from 0x7FFF to 1. The stored sample is {1, r, 0, r}, so the upper word is 0x8000|r and the lower word is r.
- R11: A write to the acknowledge register while `frame_rdy` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe, one sample per high cycle |
| smp_data | input | 32 | Sample value |
| host_rd | input | 1 | Host register read strobe |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data, valid the cycle after `host_rd` and held until the next read |
| frame_rdy | output | 1 | Level request: a complete frame waits to be drained |

## Verification
The assertions assume the following about the inputs:
- The host never reads and writes in the same cycle.
- The channel and scan registers only change while capture is disabled, which the block itself enforces.
- Every sample strobe lasts exactly one cycle per sample.

The stimulus drives strobes for a single cycle away from the clock edge. It issues reads and writes from separate tasks so they never overlap. It reprograms the frame geometry only before enabling capture. The bound checks on the sample counter rely on the counter being cleared while capture is off, so the stimulus always enables capture only after a valid configuration.

// File: rtl/ppfb_pkg.sv
`timescale 1ns/1ps
package ppfb_pkg;
  localparam int HDR_WORDS = 6;
  localparam logic [15:0] HDR_MARK = 16'hC3A5;

  localparam logic [2:0] RA_DATA = 3'd0;
  localparam logic [2:0] RA_CTRL = 3'd1;
  localparam logic [2:0] RA_CHAN = 3'd2;
  localparam logic [2:0] RA_SCAN = 3'd3;
  localparam logic [2:0] RA_STAT = 3'd4;
  localparam logic [2:0] RA_ACK  = 3'd5;
  localparam logic [2:0] RA_CLR  = 3'd6;

  function automatic logic [31:0] frame_samples(input logic [7:0] ch, input logic [15:0] sc);
    return 32'(ch) * 32'(sc);
  endfunction

  function automatic logic [31:0] frame_len(input logic [7:0] ch, input logic [15:0] sc);
    return 32'(HDR_WORDS) + (frame_samples(ch, sc) << 1);
  endfunction

  function automatic logic [15:0] hdr_word(input logic [2:0] idx, input logic [15:0] seq,
                                           input logic [7:0] ch, input logic [15:0] sc,
                                           input logic [15:0] len);
    logic [15:0] w;
    case (idx)
      3'd0:    w = HDR_MARK;
      3'd1:    w = seq;
      3'd2:    w = {8'd0, ch};
      3'd3:    w = sc;
      3'd4:    w = len;
      default: w = HDR_MARK ^ seq ^ {8'd0, ch} ^ sc ^ len;
    endcase
    return w;
  endfunction

  function automatic logic [14:0] ramp_step(input logic [14:0] r);
    return (r == 15'h7FFF) ? 15'd1 : r + 15'd1;
  endfunction

  function automatic logic [31:0] ramp_sample(input logic [14:0] r);
    return {1'b1, r, 1'b0, r};
  endfunction
endpackage

// File: rtl/ppfb_store.sv
`timescale 1ns/1ps
module ppfb_store #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  localparam int DEPTH = 1 << AW;
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ppfb_fill.sv
`timescale 1ns/1ps
module ppfb_fill
  import ppfb_pkg::*;
#(
  parameter int EW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          run,
  input  logic          ramp_en,
  input  logic          smp_valid,
  input  logic [31:0]   smp_data,
  input  logic [31:0]   n_samp,
  output logic          wr_en,
  output logic [EW-1:0] wr_idx,
  output logic [31:0]   wr_data,
  output logic          done
);
  logic [31:0] cnt;
  logic [14:0] ramp_r;

  assign wr_en   = run && smp_valid;
  assign done    = wr_en && (cnt == n_samp - 32'd1);
  assign wr_idx  = cnt[EW-1:0];
  assign wr_data = ramp_en ? ramp_sample(ramp_r) : smp_data;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt    <= '0;
      ramp_r <= 15'd1;
    end else if (wr_en) begin
      cnt <= done ? 32'd0 : cnt + 32'd1;
      if (ramp_en) ramp_r <= ramp_step(ramp_r);
    end
  end

  // R1: the sample index never passes the frame size while capturing
  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < n_samp));

  // R10: the ramp value is never zero, so ramp words are never zero
  a_r10_ramp_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_r != 15'd0);
endmodule

// File: rtl/ppfb_drain.sv
`timescale 1ns/1ps
module ppfb_drain
  import ppfb_pkg::*;
#(
  parameter int EW = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        restart,
  input  logic        rd_go,
  input  logic        rdy,
  input  logic        rewind,
  input  logic        rd_half,
  input  logic [15:0] len,
  input  logic [15:0] hdr_seq,
  input  logic [7:0]  ch,
  input  logic [15:0] sc,
  output logic        mem_re,
  output logic [EW:0] mem_raddr,
  input  logic [31:0] mem_q,
  output logic [15:0] word
);
  logic [15:0] ptr;
  logic [EW:0] k;
  logic        take, in_hdr;
  logic        o_zero, o_hdr, o_lo;
  logic [15:0] hdr_q;

  assign take      = rd_go && rdy && (ptr < len);
  assign in_hdr    = ptr < 16'(HDR_WORDS);
  assign k         = (EW+1)'(ptr - 16'(HDR_WORDS));
  assign mem_re    = take && !in_hdr;
  assign mem_raddr = {rd_half, k[EW:1]};
  assign word      = o_zero ? 16'd0 : (o_hdr ? hdr_q : (o_lo ? mem_q[15:0] : mem_q[31:16]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr    <= '0;
      o_zero <= 1'b1;
      o_hdr  <= 1'b0;
      o_lo   <= 1'b0;
      hdr_q  <= '0;
    end else begin
      if (rd_go) begin
        o_zero <= !take;
        o_hdr  <= in_hdr;
        o_lo   <= k[0];
        hdr_q  <= hdr_word(ptr[2:0], hdr_seq, ch, sc, len);
      end
      if (restart || rewind) ptr <= '0;
      else if (take)         ptr <= ptr + 16'd1;
    end
  end

  // R5: a data read with no frame waiting answers zero
  a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && !rdy) |=> (word == 16'd0));

  // R5: the read position moves only on a read, an acknowledge or a clear
  a_r5_ptr_still: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_go && !rewind && !restart) |=> $stable(ptr));
endmodule

// File: rtl/pingpong_frame_buf.sv
`timescale 1ns/1ps
module pingpong_frame_buf
  import ppfb_pkg::*;
#(
  parameter int HALF_WORDS = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        smp_valid,
  input  logic [31:0] smp_data,
  input  logic        host_rd,
  input  logic        host_wr,
  input  logic [2:0]  host_addr,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  output logic        frame_rdy
);
  localparam int EW = $clog2(HALF_WORDS / 2);
  localparam int AW = EW + 1;

  logic        en, ramp_en, ovr;
  logic [7:0]  ch_q;
  logic [15:0] sc_q;
  logic [1:0]  full;
  logic        wr_half, rd_half;
  logic [15:0] seq;
  logic [15:0] half_seq [2];

  logic [31:0] n_samp, flen;
  logic        cfg_err;
  logic        wr_ctrl, wr_chan, wr_scan, ack_wr, clr_wr, ack_take, rd_go;
  logic        fill_en, fill_done;
  logic [EW-1:0] fill_idx;
  logic [31:0] fill_data, mem_q;
  logic        mem_re;
  logic [AW-1:0] mem_raddr;
  logic [15:0] drain_word, reg_q;
  logic        last_data;

  assign n_samp  = frame_samples(ch_q, sc_q);
  assign flen    = frame_len(ch_q, sc_q);
  assign cfg_err = (ch_q == 8'd0) || (sc_q == 16'd0) || (flen > 32'(HALF_WORDS));

  assign wr_ctrl  = host_wr && (host_addr == RA_CTRL);
  assign wr_chan  = host_wr && (host_addr == RA_CHAN) && !en;
  assign wr_scan  = host_wr && (host_addr == RA_SCAN) && !en;
  assign ack_wr   = host_wr && (host_addr == RA_ACK);
  assign clr_wr   = host_wr && (host_addr == RA_CLR);
  assign ack_take = ack_wr && frame_rdy;
  assign rd_go    = host_rd && (host_addr == RA_DATA);

  assign frame_rdy = full[rd_half] && !ovr;

  ppfb_fill #(.EW(EW)) u_fill (
    .clk(clk), .rst_n(rst_n), .restart(clr_wr || !en), .run(en && !ovr),
    .ramp_en(ramp_en), .smp_valid(smp_valid), .smp_data(smp_data), .n_samp(n_samp),
    .wr_en(fill_en), .wr_idx(fill_idx), .wr_data(fill_data), .done(fill_done)
  );

  ppfb_store #(.AW(AW)) u_store (
    .clk(clk), .we(fill_en), .waddr({wr_half, fill_idx}), .wdata(fill_data),
    .re(mem_re), .raddr(mem_raddr), .rdata(mem_q)
  );

  ppfb_drain #(.EW(EW)) u_drain (
    .clk(clk), .rst_n(rst_n), .restart(clr_wr), .rd_go(rd_go), .rdy(frame_rdy),
    .rewind(ack_take), .rd_half(rd_half), .len(flen[15:0]), .hdr_seq(half_seq[rd_half]),
    .ch(ch_q), .sc(sc_q), .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_q(mem_q),
    .word(drain_word)
  );

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en      <= 1'b0;
      ramp_en <= 1'b0;
      ch_q    <= 8'd1;
      sc_q    <= 16'd1;
    end else begin
      if (wr_ctrl) begin
        en      <= host_wdata[0] && !cfg_err;
        ramp_en <= host_wdata[1];
      end
      if (wr_chan) ch_q <= host_wdata[7:0];
      if (wr_scan) sc_q <= host_wdata;
    end
  end

  // half ownership, sequence and overrun
  always_ff @(posedge clk) begin
    if (!rst_n || clr_wr) begin
      full        <= 2'b00;
      wr_half     <= 1'b0;
      rd_half     <= 1'b0;
      ovr         <= 1'b0;
      seq         <= '0;
      half_seq[0] <= '0;
      half_seq[1] <= '0;
    end else begin
      if (ack_take) begin
        full[rd_half] <= 1'b0;
        rd_half       <= ~rd_half;
      end
      if (fill_done) begin
        full[wr_half]     <= 1'b1;
        wr_half           <= ~wr_half;
        half_seq[wr_half] <= seq;
        seq               <= seq + 16'd1;
        if (full[~wr_half] && !ack_take) ovr <= 1'b1;
      end
    end
  end

  // host read return path
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_data <= 1'b0;
      reg_q     <= '0;
    end else if (host_rd) begin
      last_data <= (host_addr == RA_DATA);
      case (host_addr)
        RA_CTRL: reg_q <= {14'd0, ramp_en, en};
        RA_CHAN: reg_q <= {8'd0, ch_q};
        RA_SCAN: reg_q <= sc_q;
        RA_STAT: reg_q <= {13'd0, cfg_err, ovr, frame_rdy};
        default: reg_q <= '0;
      endcase
    end
  end

  assign host_rdata = last_data ? drain_word : reg_q;

  // R6: no request while the overrun flag is up
  a_r6_quiet_on_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |-> !frame_rdy);

  // R6, R7: the overrun flag is left only through a clear write
  a_r7_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !clr_wr) |=> ovr);

  // R2: an accepted acknowledge drops the request
  a_r2_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && !fill_done && !clr_wr) |=> !frame_rdy);

  // R2: the request is a level held until acknowledged
  a_r2_rdy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_rdy && !ack_wr && !clr_wr && !fill_done) |=> frame_rdy);

  // R8: capture only ever runs with a fitting geometry
  a_r8_en_fits: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> !cfg_err);

  // R3: both halves full only together with overrun
  a_r3_one_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (full == 2'b11) |-> ovr);
endmodule

// File: tb/pingpong_frame_buf_bench.sv
`timescale 1ns/1ps
module pingpong_frame_buf_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [31:0] smp_data = '0;
  logic        host_rd = 1'b0;
  logic        host_wr = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        frame_rdy;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pingpong_frame_buf u_pingpong_frame_buf (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .frame_rdy(frame_rdy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic push(input logic [31:0] d);
    @(negedge clk);
    smp_valid = 1'b1; smp_data = d;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  function automatic logic [31:0] pat(input logic [15:0] base, input int i);
    logic [15:0] v;
    v = base + 16'(i);
    return {v, ~v};
  endfunction

  task automatic push_range(input logic [15:0] base, input int from, input int upto);
    for (int i = from; i < upto; i++) push(pat(base, i));
  endtask

  // reads a full frame and one extra word, comparing against R1 layout
  task automatic read_frame(input string req, input int ch, input int sc, input int sq,
                            input logic [15:0] base, input bit ramp);
    logic [15:0] got, hx, w;
    int n, len;
    logic [31:0] s;
    n = ch * sc;
    len = 6 + 2 * n;
    hx = 16'hC3A5 ^ 16'(sq) ^ 16'(ch) ^ 16'(sc) ^ 16'(len);
    for (int j = 0; j < 6; j++) begin
      case (j)
        0: w = 16'hC3A5;
        1: w = 16'(sq);
        2: w = 16'(ch);
        3: w = 16'(sc);
        4: w = 16'(len);
        default: w = hx;
      endcase
      rd(3'd0, got);
      check({req, " R1 header"}, {16'd0, got}, {16'd0, w});
    end
    for (int i = 0; i < n; i++) begin
      s = ramp ? {1'b1, 15'(i + 1), 1'b0, 15'(i + 1)} : pat(base, i);
      rd(3'd0, got);
      check({req, " R1 hi"}, {16'd0, got}, {16'd0, s[31:16]});
      rd(3'd0, got);
      check({req, " R1 lo"}, {16'd0, got}, {16'd0, s[15:0]});
    end
    rd(3'd0, got);
    check({req, " R4 past end"}, {16'd0, got}, 32'd0);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    check("R2 reset rdy", {31'd0, frame_rdy}, 32'd0);
    rd(3'd4, d);
    check("R8 reset status", {16'd0, d}, 32'd0);
    rd(3'd2, d);
    check("R9 reset channels", {16'd0, d}, 32'd1);
  endtask

  task automatic t_config;
    logic [15:0] d;
    wr(3'd2, 16'd1);
    wr(3'd3, 16'd510);
    rd(3'd4, d);
    check("R8 oversize flagged", {16'd0, d}, 32'd4);
    wr(3'd1, 16'd1);
    rd(3'd1, d);
    check("R8 enable refused", {16'd0, d}, 32'd0);
    wr(3'd3, 16'd509);
    rd(3'd4, d);
    check("R8 exact fit ok", {16'd0, d}, 32'd0);
    wr(3'd2, 16'd0);
    rd(3'd4, d);
    check("R8 zero channels", {16'd0, d}, 32'd4);
    wr(3'd2, 16'd2);
    wr(3'd3, 16'd3);
    wr(3'd1, 16'd1);
    rd(3'd1, d);
    check("R8 enable accepted", {16'd0, d}, 32'd1);
  endtask

  task automatic t_locked;
    logic [15:0] d;
    wr(3'd2, 16'd7);
    wr(3'd3, 16'd9);
    rd(3'd2, d);
    check("R9 channels locked", {16'd0, d}, 32'd2);
    rd(3'd3, d);
    check("R9 scans locked", {16'd0, d}, 32'd3);
  endtask

  task automatic t_first_frame;
    logic [15:0] d;
    rd(3'd0, d);
    check("R5 idle read zero", {16'd0, d}, 32'd0);
    wr(3'd5, 16'd1);
    check("R11 stray ack", {31'd0, frame_rdy}, 32'd0);
    push_range(16'h0100, 0, 5);
    check("R2 not early", {31'd0, frame_rdy}, 32'd0);
    push_range(16'h0100, 5, 6);
    check("R2 rdy after last", {31'd0, frame_rdy}, 32'd1);
    read_frame("R5 first", 2, 3, 0, 16'h0100, 1'b0);
    check("R2 held until ack", {31'd0, frame_rdy}, 32'd1);
    wr(3'd5, 16'd1);
    check("R2 ack drops", {31'd0, frame_rdy}, 32'd0);
  endtask

  task automatic t_pingpong;
    push_range(16'h0200, 0, 6);
    check("R3 frame A ready", {31'd0, frame_rdy}, 32'd1);
    push_range(16'h0300, 0, 3);
    read_frame("R3 A", 2, 3, 1, 16'h0200, 1'b0);
    wr(3'd5, 16'd1);
    check("R3 B not complete", {31'd0, frame_rdy}, 32'd0);
    push_range(16'h0300, 3, 6);
    check("R3 B ready", {31'd0, frame_rdy}, 32'd1);
    read_frame("R3 B", 2, 3, 2, 16'h0300, 1'b0);
    wr(3'd5, 16'd1);
  endtask

  task automatic t_overrun;
    logic [15:0] d;
    push_range(16'h0400, 0, 6);
    push_range(16'h0450, 0, 6);
    rd(3'd4, d);
    check("R6 overrun status", {16'd0, d}, 32'd2);
    check("R6 rdy low", {31'd0, frame_rdy}, 32'd0);
    push_range(16'h0460, 0, 6);
    rd(3'd4, d);
    check("R6 sticky", {16'd0, d}, 32'd2);
    rd(3'd0, d);
    check("R6 no data", {16'd0, d}, 32'd0);
    wr(3'd6, 16'd0);
    rd(3'd4, d);
    check("R7 clear status", {16'd0, d}, 32'd0);
    push_range(16'h0500, 0, 6);
    check("R7 capture resumes", {31'd0, frame_rdy}, 32'd1);
    read_frame("R7 seq restart", 2, 3, 0, 16'h0500, 1'b0);
    wr(3'd5, 16'd1);
  endtask

  task automatic t_ramp;
    wr(3'd6, 16'd0);
    wr(3'd1, 16'd3);
    for (int i = 0; i < 6; i++) push(32'd0);
    check("R10 ramp ready", {31'd0, frame_rdy}, 32'd1);
    read_frame("R10 ramp", 2, 3, 0, 16'h0000, 1'b1);
    wr(3'd5, 16'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_config();
    t_locked();
    t_first_frame();
    t_pingpong();
    t_overrun();
    t_ramp();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule